// File: doc/BRIEF.md
# Erase Command Ordering Controller

This block sits on the card side of a memory-card command path, behind the command decoder. It watches every decoded command (a 6-bit index, a 32-bit byte-address argument and a valid strobe) and enforces the only legal erase ordering: set the first block (index 32), then set the last block (index 33), then start the erase (index 38). The two addresses are turned into block numbers by dropping the byte offset inside a 512-byte block. When the erase command closes a valid ordered sequence, the block issues a one-cycle erase request. The request carries the block range, a mask of the write-protected regions inside that range that the eraser must skip, and the fill value that erased cells take.

Three sticky status flags report erase trouble: an ordering error, a sequence reset caused by an unrelated command, and a write-protect skip. A status-clear strobe models the status read that empties them.

The ordering is held in a three-state machine. `ST_IDLE` waits for index 32, which latches the first block and moves to `ST_GOT_START`. There, index 33 latches the last block and moves to `ST_GOT_END`. In `ST_GOT_END`, index 38 returns to `ST_IDLE` and either fires the request or, if the range is reversed, flags an ordering error. In `ST_GOT_START` or `ST_GOT_END`, any other erase index is an ordering error and returns to `ST_IDLE`. The status query (index 13) keeps the current state. Any other command is a sequence reset and returns to `ST_IDLE`. In `ST_IDLE`, index 33 or 38 is an ordering error, and every other command is left alone.

Top module: `erase_order_ctrl`

## Requirements
- R1: A valid index 32, then a valid index 33, then a valid index 38 with last block >= first block drive `erase_req` high for exactly the one cycle after the edge that took index 38.
- R2: Index 33 or 38 in `ST_IDLE`, index 32 or 38 in `ST_GOT_START`, and index 32 or 33 in `ST_GOT_END` each set `st_seq_err`, return to `ST_IDLE` and issue no request.
- R3: Any index other than 32, 33, 38 and 13 sets `st_seq_reset` and returns to `ST_IDLE` when it arrives in `ST_GOT_START` or `ST_GOT_END`. In `ST_IDLE` it changes no flag.
- R4: Index 13 changes neither the state nor any status flag, so a sequence interrupted by it still completes.
- R5: The block number is argument bits [31:9]. Bits [8:0] are ignored, and `erase_first_blk` and `erase_last_blk` show the latched block numbers.
- R6: Region r covers blocks 16r to 16r+15 for r in 0..7, and `wp_map` bit r protects region r. On a request, `erase_skip_mask` bit r is 1 when region r overlaps the range and is protected. `st_wp_skip` is set when that mask is nonzero.
- R7: On a request, `erase_fill_ones` takes the value of `fill_ones_cfg` (1 means all ones, 0 means all zeros) and holds it until the next request.
- R8: Status flags stay set until a cycle with `status_clr` high. An event in the same cycle as the clear leaves its flag set.
- R9: Index 38 in `ST_GOT_END` with last block < first block issues no request, sets `st_seq_err` and returns to `ST_IDLE`.
- R10: After reset, `erase_req`, `erase_skip_mask`, `erase_fill_ones` and all status flags are 0, and the state is `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Decoded command present this cycle |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Byte-address argument |
| wp_map | input | 8 | Write-protect bit per region |
| fill_ones_cfg | input | 1 | Erased value select: 1 all ones, 0 all zeros |
| status_clr | input | 1 | Clears the sticky status flags |
| erase_req | output | 1 | One-cycle erase request |
| erase_first_blk | output | 23 | First block of the range |
| erase_last_blk | output | 23 | Last block of the range |
| erase_skip_mask | output | 8 | Protected regions to skip in the request |
| erase_fill_ones | output | 1 | Fill value carried with the request |
| st_seq_err | output | 1 | Sticky ordering error flag |
| st_seq_reset | output | 1 | Sticky sequence-reset flag |
| st_wp_skip | output | 1 | Sticky write-protect skip flag |

## Verification
The status clear and a new status event can fall in the same cycle. The bench provokes this by raising `status_clr` together with an out-of-order erase index, a reversed-range erase or a mid-sequence foreign command, and also at random across a long mixed command stream. The judgment is that the flag raised by that same command survives, while flags with no new event are emptied. A bench model of the ordering and flag rules checks every sample.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_GOT_START = 2'd1,
        ST_GOT_END   = 2'd2
    } erase_st_e;

    localparam logic [5:0] IDX_SET_FIRST = 6'd32;
    localparam logic [5:0] IDX_SET_LAST  = 6'd33;
    localparam logic [5:0] IDX_DO_ERASE  = 6'd38;
    localparam logic [5:0] IDX_STATUS    = 6'd13;
endpackage

// File: rtl/erase_seq_fsm.sv
module erase_seq_fsm
    import erase_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [5:0] cmd_index,
    input  logic       range_ok,
    output logic       ld_first,
    output logic       ld_last,
    output logic       ev_fire,
    output logic       ev_seq_err,
    output logic       ev_reset
);
    erase_st_e st_q, st_d;
    logic      is_seq_cmd;
    logic      is_status;

    assign is_seq_cmd = (cmd_index == IDX_SET_FIRST) || (cmd_index == IDX_SET_LAST) ||
                        (cmd_index == IDX_DO_ERASE);
    assign is_status  = (cmd_index == IDX_STATUS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d       = st_q;
        ld_first   = 1'b0;
        ld_last    = 1'b0;
        ev_fire    = 1'b0;
        ev_seq_err = 1'b0;
        ev_reset   = 1'b0;
        if (cmd_valid) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (cmd_index == IDX_SET_FIRST) begin
                        ld_first = 1'b1;
                        st_d     = ST_GOT_START;
                    end else if (is_seq_cmd) begin
                        ev_seq_err = 1'b1;
                    end
                end
                ST_GOT_START: begin
                    if (cmd_index == IDX_SET_LAST) begin
                        ld_last = 1'b1;
                        st_d    = ST_GOT_END;
                    end else if (is_seq_cmd) begin
                        ev_seq_err = 1'b1;
                        st_d       = ST_IDLE;
                    end else if (!is_status) begin
                        ev_reset = 1'b1;
                        st_d     = ST_IDLE;
                    end
                end
                ST_GOT_END: begin
                    if (cmd_index == IDX_DO_ERASE) begin
                        st_d = ST_IDLE;
                        if (range_ok) ev_fire    = 1'b1;
                        else          ev_seq_err = 1'b1;
                    end else if (is_seq_cmd) begin
                        ev_seq_err = 1'b1;
                        st_d       = ST_IDLE;
                    end else if (!is_status) begin
                        ev_reset = 1'b1;
                        st_d     = ST_IDLE;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/erase_range_reg.sv
module erase_range_reg #(
    parameter int ADDR_W    = 32,
    parameter int BLK_SHIFT = 9,
    localparam int BLK_W    = ADDR_W - BLK_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_first,
    input  logic              ld_last,
    input  logic [ADDR_W-1:0] cmd_arg,
    output logic [BLK_W-1:0]  first_blk,
    output logic [BLK_W-1:0]  last_blk,
    output logic              range_ok
);
    logic [BLK_W-1:0] arg_blk;

    assign arg_blk  = BLK_W'(cmd_arg >> BLK_SHIFT);
    assign range_ok = (last_blk >= first_blk);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_blk <= '0;
            last_blk  <= '0;
        end else begin
            if (ld_first) first_blk <= arg_blk;
            if (ld_last)  last_blk  <= arg_blk;
        end
    end
endmodule

// File: rtl/erase_wp_map.sv
module erase_wp_map #(
    parameter int BLK_W     = 23,
    parameter int REG_SHIFT = 4,
    parameter int NREG      = 8
) (
    input  logic [BLK_W-1:0] first_blk,
    input  logic [BLK_W-1:0] last_blk,
    input  logic [NREG-1:0]  wp_map,
    output logic [NREG-1:0]  skip_mask
);
    logic [BLK_W-1:0] lo_reg;
    logic [BLK_W-1:0] hi_reg;

    assign lo_reg = first_blk >> REG_SHIFT;
    assign hi_reg = last_blk >> REG_SHIFT;

    for (genvar r = 0; r < NREG; r++) begin : g_region
        localparam logic [BLK_W-1:0] RIDX = BLK_W'(r);
        assign skip_mask[r] = wp_map[r] && (RIDX >= lo_reg) && (RIDX <= hi_reg);
    end
endmodule

// File: rtl/erase_status.sv
module erase_status (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set_err,
    input  logic set_reset,
    input  logic set_skip,
    output logic st_err,
    output logic st_reset,
    output logic st_skip
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_err   <= 1'b0;
            st_reset <= 1'b0;
            st_skip  <= 1'b0;
        end else begin
            st_err   <= (st_err   && !clr) || set_err;
            st_reset <= (st_reset && !clr) || set_reset;
            st_skip  <= (st_skip  && !clr) || set_skip;
        end
    end
endmodule

// File: rtl/erase_order_ctrl.sv
module erase_order_ctrl #(
    parameter int ADDR_W    = 32,
    parameter int BLK_SHIFT = 9,
    parameter int REG_SHIFT = 4,
    parameter int NREG      = 8,
    localparam int BLK_W    = ADDR_W - BLK_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [5:0]        cmd_index,
    input  logic [ADDR_W-1:0] cmd_arg,
    input  logic [NREG-1:0]   wp_map,
    input  logic              fill_ones_cfg,
    input  logic              status_clr,
    output logic              erase_req,
    output logic [BLK_W-1:0]  erase_first_blk,
    output logic [BLK_W-1:0]  erase_last_blk,
    output logic [NREG-1:0]   erase_skip_mask,
    output logic              erase_fill_ones,
    output logic              st_seq_err,
    output logic              st_seq_reset,
    output logic              st_wp_skip
);
    logic            ld_first, ld_last, range_ok;
    logic            ev_fire, ev_seq_err, ev_reset;
    logic [NREG-1:0] skip_now;

    erase_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_index  (cmd_index),
        .range_ok   (range_ok),
        .ld_first   (ld_first),
        .ld_last    (ld_last),
        .ev_fire    (ev_fire),
        .ev_seq_err (ev_seq_err),
        .ev_reset   (ev_reset)
    );

    erase_range_reg #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT)) u_range (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_first  (ld_first),
        .ld_last   (ld_last),
        .cmd_arg   (cmd_arg),
        .first_blk (erase_first_blk),
        .last_blk  (erase_last_blk),
        .range_ok  (range_ok)
    );

    erase_wp_map #(.BLK_W(BLK_W), .REG_SHIFT(REG_SHIFT), .NREG(NREG)) u_wp (
        .first_blk (erase_first_blk),
        .last_blk  (erase_last_blk),
        .wp_map    (wp_map),
        .skip_mask (skip_now)
    );

    erase_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (status_clr),
        .set_err   (ev_seq_err),
        .set_reset (ev_reset),
        .set_skip  (ev_fire && (|skip_now)),
        .st_err    (st_seq_err),
        .st_reset  (st_seq_reset),
        .st_skip   (st_wp_skip)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            erase_req       <= 1'b0;
            erase_skip_mask <= '0;
            erase_fill_ones <= 1'b0;
        end else begin
            erase_req <= ev_fire;
            if (ev_fire) begin
                erase_skip_mask <= skip_now;
                erase_fill_ones <= fill_ones_cfg;
            end
        end
    end
endmodule

// File: rtl/erase_order_guard.sv
module erase_order_guard #(
    parameter int BLK_W = 23,
    parameter int NREG  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [5:0]       cmd_index,
    input logic             status_clr,
    input logic             erase_req,
    input logic [BLK_W-1:0] erase_first_blk,
    input logic [BLK_W-1:0] erase_last_blk,
    input logic [NREG-1:0]  erase_skip_mask,
    input logic             st_seq_err,
    input logic             st_seq_reset,
    input logic             st_wp_skip
);
    p_req_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> !erase_req);

    p_req_after_go_r1: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> $past(cmd_valid && cmd_index == 6'd38));

    p_range_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> (erase_last_blk >= erase_first_blk));

    p_skip_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && (|erase_skip_mask)) |-> st_wp_skip);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_seq_err) && !$past(status_clr)) |-> st_seq_err);

    p_err_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_seq_err) |-> $past(cmd_valid && (cmd_index == 6'd32 ||
                                    cmd_index == 6'd33 || cmd_index == 6'd38)));

    p_status_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_valid && cmd_index == 6'd13) |-> !erase_req);

    p_reset_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_seq_reset) |-> $past(cmd_valid && cmd_index != 6'd13));
endmodule

bind erase_order_ctrl erase_order_guard #(.BLK_W(BLK_W), .NREG(NREG)) u_guard (.*);

// File: tb/tb_erase_order_ctrl.sv
module tb_erase_order_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic [7:0]  wp_map = '0;
    logic        fill_ones_cfg = 1'b0;
    logic        status_clr = 1'b0;
    logic        erase_req;
    logic [22:0] erase_first_blk, erase_last_blk;
    logic [7:0]  erase_skip_mask;
    logic        erase_fill_ones, st_seq_err, st_seq_reset, st_wp_skip;

    int total = 0;
    int bad = 0;

    // reference model state: 0 idle, 1 have first, 2 have last
    int          m_st = 0;
    logic [22:0] m_first = '0, m_last = '0;
    logic        m_err = 0, m_rst = 0, m_skip = 0;

    erase_order_ctrl dut (.*);

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] prot_hit(input logic [22:0] f, input logic [22:0] l,
                                            input logic [7:0] wp);
        logic [7:0] m = '0;
        for (int r = 0; r < 8; r++)
            if ((r * 16 + 15) >= int'(f) && (r * 16) <= int'(l)) m[r] = wp[r];
        return m;
    endfunction

    task automatic do_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic clr,
                          input string tag);
        logic [22:0] b = arg[31:9];
        logic e_req = 0, e_err = 0, e_rst = 0, e_skp = 0;
        logic [7:0] e_mask = '0;
        bit seq = (idx == 32 || idx == 33 || idx == 38);
        if (m_st == 0) begin
            if (idx == 32) begin m_first = b; m_st = 1; end
            else if (seq) e_err = 1;
        end else if (m_st == 1) begin
            if (idx == 33) begin m_last = b; m_st = 2; end
            else if (seq) begin e_err = 1; m_st = 0; end
            else if (idx != 13) begin e_rst = 1; m_st = 0; end
        end else begin
            if (idx == 38) begin
                m_st = 0;
                if (m_last >= m_first) begin
                    e_req = 1;
                    e_mask = prot_hit(m_first, m_last, wp_map);
                    e_skp = |e_mask;
                end else e_err = 1;
            end else if (seq) begin e_err = 1; m_st = 0; end
            else if (idx != 13) begin e_rst = 1; m_st = 0; end
        end
        m_err  = (m_err  && !clr) || e_err;
        m_rst  = (m_rst  && !clr) || e_rst;
        m_skip = (m_skip && !clr) || e_skp;
        @(negedge clk);
        cmd_valid = 1; cmd_index = idx; cmd_arg = arg; status_clr = clr;
        @(negedge clk);
        cmd_valid = 0; status_clr = 0;
        chk({tag, " R1 req"}, erase_req, e_req);
        chk({tag, " R2 R9 seq_err"}, st_seq_err, m_err);
        chk({tag, " R3 seq_reset"}, st_seq_reset, m_rst);
        chk({tag, " R8 wp_skip flag"}, st_wp_skip, m_skip);
        if (e_req) begin
            chk({tag, " R5 first"}, erase_first_blk, m_first);
            chk({tag, " R5 last"}, erase_last_blk, m_last);
            chk({tag, " R6 mask"}, erase_skip_mask, e_mask);
            chk({tag, " R7 fill"}, erase_fill_ones, fill_ones_cfg);
        end
    endtask

    initial begin
        #800000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R10 reset req", erase_req, 0);
        chk("R10 reset mask", erase_skip_mask, 0);
        chk("R10 reset flags", {st_seq_err, st_seq_reset, st_wp_skip, erase_fill_ones}, 0);

        // legal order, status query mid-sequence, truncation, protect skip, fill
        wp_map = 8'h02; fill_ones_cfg = 1;
        do_cmd(32, 32'h0000_05FF, 0, "dir legal");
        do_cmd(13, 32'h0, 0, "dir R4 status mid");
        do_cmd(33, 32'h0000_2A10, 0, "dir legal");
        do_cmd(38, 32'h0, 0, "dir legal go");
        chk("R5 first trunc", erase_first_blk, 2);
        chk("R5 last trunc", erase_last_blk, 21);
        chk("R6 skip mask", erase_skip_mask, 8'h02);
        chk("R6 skip flag", st_wp_skip, 1);
        chk("R7 fill ones", erase_fill_ones, 1);
        do_cmd(13, 32'h0, 1, "dir R8 clear");
        chk("R8 cleared", st_wp_skip, 0);

        // out of order
        do_cmd(33, 32'h400, 0, "dir R2 last first");
        chk("R2 seq err", st_seq_err, 1);
        do_cmd(38, 32'h0, 0, "dir R2 go idle");
        chk("R2 no req", erase_req, 0);

        // foreign command resets, then stray last-block is an error
        do_cmd(13, 32'h0, 1, "dir clr");
        do_cmd(32, 32'h200, 0, "dir R3");
        do_cmd(17, 32'h0, 0, "dir R3 foreign");
        chk("R3 reset flag", st_seq_reset, 1);
        do_cmd(33, 32'h800, 0, "dir R3 after");
        chk("R3 back to idle", st_seq_err, 1);

        // reversed range
        do_cmd(13, 32'h0, 1, "dir clr");
        do_cmd(32, 50 * 512, 0, "dir R9");
        do_cmd(33, 10 * 512, 0, "dir R9");
        do_cmd(38, 32'h0, 0, "dir R9 go");
        chk("R9 no req", erase_req, 0);
        chk("R9 err", st_seq_err, 1);

        // clear coinciding with a new error
        do_cmd(32, 32'h0, 0, "dir R8 coincide");
        do_cmd(38, 32'h0, 1, "dir R8 coincide go");
        chk("R8 set beats clear", st_seq_err, 1);

        // foreign command in idle leaves flags alone
        do_cmd(13, 32'h0, 1, "dir clr");
        do_cmd(24, 32'h0, 0, "dir R3 idle foreign");
        chk("R3 idle no reset", st_seq_reset, 0);

        // fill zeros
        fill_ones_cfg = 0; wp_map = 8'h00;
        do_cmd(32, 32'h0, 0, "dir R7");
        do_cmd(33, 32'h0, 0, "dir R7");
        do_cmd(38, 32'h0, 0, "dir R7 go");
        chk("R7 fill zeros", erase_fill_ones, 0);
        chk("R6 no skip", erase_skip_mask, 0);

        // constrained random
        for (int i = 0; i < 600; i++) begin
            logic [5:0]  idx;
            logic [31:0] arg;
            int sel = $urandom % 10;
            case (sel)
                0, 1, 2: idx = 32;
                3, 4, 5: idx = 33;
                6, 7:    idx = 38;
                8:       idx = 13;
                default: idx = ($urandom % 2) ? 6'd17 : 6'd24;
            endcase
            arg = ($urandom % 8 == 0) ? $urandom : ($urandom % 65536);
            if ($urandom % 8 == 0) wp_map = 8'($urandom);
            if ($urandom % 8 == 0) fill_ones_cfg = 1'($urandom);
            do_cmd(idx, arg, ($urandom % 6 == 0), "rnd");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule